// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Access Controller

This block is a hardware master for a small three-wire serial EEPROM organised as 64 words of 16 bits. A host places an operation code, a 6-bit word address and, for writes, a 16-bit data word on the command inputs and pulses `cmd_valid` for one clock. The block then produces chip select, the shift clock and the serial data line toward the memory, samples the memory's serial output, and reports completion with a one-cycle `done` pulse. Read results appear on `rdata`.

Each pin level is held for one "step" of `half_div + 1` system clocks, so a full shift-clock period is two steps. Writes and erases are automatically preceded by a write-enable frame. After the frame that changes the memory, the block polls the memory's ready indication. If the memory never reports ready within the configured number of polls, a timeout flag is raised.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After reset and whenever `busy` is low, `ee_cs`, `ee_sk` and `ee_di` are low, and `done` and `timeout_err` are low after reset. `rdata` is zero after reset.
- R2: `half_div` is captured when a command is accepted, and each step lasts `half_div + 1` clocks. `done` is seen S×(`half_div`+1) clocks after the accepting edge. S is 58 for read, 23 for write-enable, 79+P for write and 47+P for erase, where P is the number of ready polls.
- R3: `cmd_op` encodes read = 0, write-enable = 1, write = 2 and erase = 3. A read sends 11 bits most significant first: 0,0,1,1,0 and then the address from bit 5 down to bit 0. The memory takes each bit on a rising `ee_sk` while `ee_cs` is high, and `ee_di` never changes on a rising `ee_sk`.
- R4: After the read command, 16 further shift-clock pulses are given with `ee_di` low. `ee_do` is sampled at the end of each high phase, and the first sample lands in `rdata[0]`. `rdata` changes only during reads.
- R5: A write-enable sends the 10 bits 0100110000 in a single chip-select session.
- R6: A write sends the write-enable frame, drops chip select for one shift-clock period, and then sends 0,1,0,1, the address bits 5..0 and the data bits 0..15, in that order.
- R7: An erase sends the write-enable frame, the one-period deselect, and then 0,1,1,1 with the address bits 5..0, with no data bits.
- R8: After a write or erase frame, chip select is low for one shift-clock period and then high with `ee_sk` low. `ee_do` is sampled once per step, and the first 1 ends the poll. A write or erase therefore uses three chip-select sessions.
- R9: If `POLL_LIMIT` consecutive poll samples are 0, `timeout_err` is set and the access still finishes normally. The flag clears when the next command is accepted.
- R10: Every access ends with one step of chip select high and the clock low, then one step with all pins low. `done` is then a single-cycle pulse in the cycle `busy` falls.
- R11: A `cmd_valid` or `half_div` change while `busy` is high has no effect on the running access and starts no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command request, taken only when idle |
| cmd_op | input | 2 | Operation: 0 read, 1 write-enable, 2 write, 3 erase |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Data word for writes |
| half_div | input | DIV_W | Step length minus one, in system clocks |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Ready poll exhausted on the last access |
| rdata | output | 16 | Last word read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data / ready from the memory |

## Verification
Two events can fall in the same cycle: a fresh command request and a running access, including a step boundary or data sample of that access. The bench raises `cmd_valid` with a different operation, and at the same time changes `half_div`, a few cycles into a read whose step length it knows. It then judges the result from the ports alone. The recorded bit stream and the chip-select session count must match the read only. The completion time must still follow the original step length, exactly one `done` pulse must appear, and `busy` must stay low afterwards.

// File: rtl/uw_pkg.sv
package uw_pkg;

  localparam int ADDR_W  = 6;
  localparam int WORD_W  = 16;
  localparam int FRAME_W = 26;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int EN_LEN  = 10;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WREN  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } uw_op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_SH_LO, PH_SH_HI, PH_GAP_LO, PH_GAP_HI,
    PH_SETTLE, PH_IN_HI, PH_IN_LO, PH_DSL_LO, PH_DSL_HI, PH_POLL,
    PH_TAIL, PH_END
  } uw_phase_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } uw_pins_t;

  localparam logic [FRAME_W-1:0] EN_FRAME = {10'b0100110000, 16'h0000};

  function automatic logic [WORD_W-1:0] bit_reverse(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction

  function automatic logic needs_enable(input uw_op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE);
  endfunction

  function automatic logic [FRAME_W-1:0] frame_bits(input uw_op_e op,
                                                    input logic [ADDR_W-1:0] a,
                                                    input logic [WORD_W-1:0] d);
    case (op)
      OP_READ:  return {5'b00110, a, 15'h0000};
      OP_WREN:  return EN_FRAME;
      OP_WRITE: return {4'b0101, a, bit_reverse(d)};
      default:  return {4'b0111, a, 16'h0000};
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input uw_op_e op);
    case (op)
      OP_READ:  return CNT_W'(11);
      OP_WRITE: return CNT_W'(FRAME_W);
      default:  return CNT_W'(EN_LEN);
    endcase
  endfunction

  function automatic uw_pins_t pins_for(input uw_phase_e ph, input logic msb);
    uw_pins_t p;
    p = '0;
    case (ph)
      PH_LEAD, PH_SETTLE, PH_IN_LO, PH_POLL, PH_TAIL: p.cs = 1'b1;
      PH_SH_LO:  begin p.cs = 1'b1; p.di = msb; end
      PH_SH_HI:  begin p.cs = 1'b1; p.sk = 1'b1; p.di = msb; end
      PH_IN_HI:  begin p.cs = 1'b1; p.sk = 1'b1; end
      PH_GAP_HI, PH_DSL_HI: p.sk = 1'b1;
      default:   p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/uw_step_timer.sv
module uw_step_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div_q);
    div_d = start ? half_div : div_q;
    if (start || !run || tick) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/uw_rx_capture.sv
module uw_rx_capture #(
  parameter int W     = 16,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic             cap_bit,
  output logic [W-1:0]     word
);

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic hit;
    assign hit = cap_en && (cap_idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word[gi] <= 1'b0;
      else if (hit) word[gi] <= cap_bit;
    end
  end

endmodule

// File: rtl/uw_sequencer.sv
module uw_sequencer
  import uw_pkg::*;
#(
  parameter int POLL_LIMIT = 4096,
  parameter int POLL_W     = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  uw_op_e            cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic              tick,
  input  logic              ee_do,
  output logic              start,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output uw_pins_t          pins
);

  uw_phase_e          ph_q, ph_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   left_q, left_d;
  uw_op_e             op_q, op_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [WORD_W-1:0]  wdata_q, wdata_d;
  logic               chain_q, chain_d;
  logic [POLL_W-1:0]  poll_q, poll_d;
  logic               tmo_q, tmo_d;
  logic               done_q, done_d;
  uw_pins_t           pins_q, pins_d;

  always_comb begin
    ph_d    = ph_q;
    sr_d    = sr_q;
    left_d  = left_q;
    op_d    = op_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    chain_d = chain_q;
    poll_d  = poll_q;
    tmo_d   = tmo_q;
    done_d  = 1'b0;
    start   = 1'b0;
    cap_en  = 1'b0;
    cap_idx = IDX_W'(CNT_W'(WORD_W) - left_q);
    case (ph_q)
      PH_IDLE: begin
        if (cmd_valid) begin
          start   = 1'b1;
          op_d    = cmd_op;
          addr_d  = cmd_addr;
          wdata_d = cmd_wdata;
          tmo_d   = 1'b0;
          ph_d    = PH_LEAD;
          if (needs_enable(cmd_op)) begin
            sr_d    = EN_FRAME;
            left_d  = CNT_W'(EN_LEN);
            chain_d = 1'b1;
          end else begin
            sr_d    = frame_bits(cmd_op, cmd_addr, cmd_wdata);
            left_d  = frame_len(cmd_op);
            chain_d = 1'b0;
          end
        end
      end
      PH_LEAD:   if (tick) ph_d = PH_SH_LO;
      PH_SH_LO:  if (tick) ph_d = PH_SH_HI;
      PH_SH_HI: begin
        if (tick) begin
          sr_d   = {sr_q[FRAME_W-2:0], 1'b0};
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            if (chain_q)               ph_d = PH_GAP_LO;
            else if (op_q == OP_READ) begin
              ph_d   = PH_SETTLE;
              left_d = CNT_W'(WORD_W);
            end
            else if (op_q == OP_WREN)  ph_d = PH_TAIL;
            else                       ph_d = PH_DSL_LO;
          end else begin
            ph_d = PH_SH_LO;
          end
        end
      end
      PH_GAP_LO: if (tick) ph_d = PH_GAP_HI;
      PH_GAP_HI: begin
        if (tick) begin
          sr_d    = frame_bits(op_q, addr_q, wdata_q);
          left_d  = frame_len(op_q);
          chain_d = 1'b0;
          ph_d    = PH_SH_LO;
        end
      end
      PH_SETTLE: if (tick) ph_d = PH_IN_HI;
      PH_IN_HI: begin
        if (tick) begin
          cap_en = 1'b1;
          ph_d   = PH_IN_LO;
        end
      end
      PH_IN_LO: begin
        if (tick) begin
          left_d = left_q - 1'b1;
          ph_d   = (left_q == CNT_W'(1)) ? PH_TAIL : PH_IN_HI;
        end
      end
      PH_DSL_LO: if (tick) ph_d = PH_DSL_HI;
      PH_DSL_HI: begin
        if (tick) begin
          poll_d = '0;
          ph_d   = PH_POLL;
        end
      end
      PH_POLL: begin
        if (tick) begin
          if (ee_do) begin
            ph_d = PH_TAIL;
          end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
            tmo_d = 1'b1;
            ph_d  = PH_TAIL;
          end else begin
            poll_d = poll_q + 1'b1;
          end
        end
      end
      PH_TAIL:   if (tick) ph_d = PH_END;
      PH_END: begin
        if (tick) begin
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      default:   ph_d = PH_IDLE;
    endcase
    pins_d = pins_for(ph_d, sr_d[FRAME_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      sr_q    <= '0;
      left_q  <= '0;
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      chain_q <= 1'b0;
      poll_q  <= '0;
      tmo_q   <= 1'b0;
      done_q  <= 1'b0;
      pins_q  <= '0;
    end else begin
      ph_q    <= ph_d;
      sr_q    <= sr_d;
      left_q  <= left_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      chain_q <= chain_d;
      poll_q  <= poll_d;
      tmo_q   <= tmo_d;
      done_q  <= done_d;
      pins_q  <= pins_d;
    end
  end

  assign busy        = (ph_q != PH_IDLE);
  assign done        = done_q;
  assign timeout_err = tmo_q;
  assign pins        = pins_q;

endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uw_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]  half_div,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [WORD_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  logic             start;
  logic             tick;
  logic             cap_en;
  logic [IDX_W-1:0] cap_idx;
  uw_pins_t         pins;

  uw_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .run      (busy),
    .half_div (half_div),
    .tick     (tick)
  );

  uw_sequencer #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (uw_op_e'(cmd_op)),
    .cmd_addr    (cmd_addr),
    .cmd_wdata   (cmd_wdata),
    .tick        (tick),
    .ee_do       (ee_do),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .cap_en      (cap_en),
    .cap_idx     (cap_idx),
    .pins        (pins)
  );

  uw_rx_capture #(.W(WORD_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .cap_bit (ee_do),
    .word    (rdata)
  );

  assign ee_cs = pins.cs;
  assign ee_sk = pins.sk;
  assign ee_di = pins.di;

endmodule

// File: rtl/uw_checker.sv
module uw_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));

  a_r3_di_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> $stable(ee_di));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_cs_drop_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (!ee_sk && !ee_di));

  a_r9_timeout_in_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (busy && ee_cs && !ee_sk));

endmodule

bind uwire_eeprom_ctrl uw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .ee_cs       (ee_cs),
  .ee_sk       (ee_sk),
  .ee_di       (ee_di)
);

// File: tb/sim_uwire_eeprom_ctrl.sv
module sim_uwire_eeprom_ctrl;

  localparam int PLIM = 8;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [5:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic [7:0]  half_div;
  logic        busy, done, timeout_err;
  logic [15:0] rdata;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do;

  uwire_eeprom_ctrl #(.DIV_W(8), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .half_div(half_div),
    .busy(busy), .done(done), .timeout_err(timeout_err), .rdata(rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [0:63] got_bits;
  int          got_n, sess_n, rise_cnt, done_cnt;
  logic        sk_prev, cs_prev;
  logic [15:0] cur_pat;
  logic        ready_lvl;
  logic [15:0] last_rd;

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // pin monitor and memory model, evaluated away from the active edge
  always @(negedge clk) begin
    if (ee_sk && !sk_prev && ee_cs) begin
      if (got_n < 64) got_bits[got_n] = ee_di;
      got_n++;
      rise_cnt++;
    end
    if (ee_cs && !cs_prev) begin
      sess_n++;
      rise_cnt = 0;
    end
    if (done) done_cnt++;
    sk_prev = ee_sk;
    cs_prev = ee_cs;
    if (rise_cnt >= 12 && rise_cnt <= 27) ee_do = cur_pat[rise_cnt-12];
    else if (rise_cnt == 0)               ee_do = ready_lvl;
    else                                  ee_do = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input int op, input logic [5:0] a, input logic [15:0] d,
                                    output logic [0:63] b, output int n, output int s);
    logic [9:0]  en;
    logic [10:0] rd;
    logic [9:0]  mf;
    b = '0; n = 0;
    en = 10'b0100110000;
    if (op == 2 || op == 3)
      for (int i = 9; i >= 0; i--) begin b[n] = en[i]; n++; end
    case (op)
      0: begin
        rd = {5'b00110, a};
        for (int i = 10; i >= 0; i--) begin b[n] = rd[i]; n++; end
        for (int i = 0; i < 16; i++) begin b[n] = 1'b0; n++; end
      end
      1: for (int i = 9; i >= 0; i--) begin b[n] = en[i]; n++; end
      2: begin
        mf = {4'b0101, a};
        for (int i = 9; i >= 0; i--) begin b[n] = mf[i]; n++; end
        for (int i = 0; i < 16; i++) begin b[n] = d[i]; n++; end
      end
      default: begin
        mf = {4'b0111, a};
        for (int i = 9; i >= 0; i--) begin b[n] = mf[i]; n++; end
      end
    endcase
    s = (op >= 2) ? 3 : 1;
  endfunction

  function automatic int exp_steps(input int op, input bit rdy);
    int p;
    p = rdy ? 1 : PLIM;
    case (op)
      0: return 58;
      1: return 23;
      2: return 79 + p;
      default: return 47 + p;
    endcase
  endfunction

  task automatic run_op(input int op, input logic [5:0] a, input logic [15:0] d,
                        input int div, input bit rdy, input logic [15:0] pat, input bit inject);
    logic [0:63] eb;
    int en, es, k, want;
    logic [15:0] exp_rd;
    exp_frame(op, a, d, eb, en, es);
    want = exp_steps(op, rdy) * (div + 1);
    @(negedge clk);
    cmd_op = 2'(op); cmd_addr = a; cmd_wdata = d; half_div = 8'(div);
    cur_pat = pat; ready_lvl = rdy;
    got_n = 0; got_bits = '0; sess_n = 0; done_cnt = 0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(timeout_err == 1'b0 && busy == 1'b1, "R9 flag cleared on accept", {timeout_err, busy}, 2'b01);
    k = 0;
    while (!done && k < 30000) begin
      @(negedge clk);
      k++;
      if (inject && k == 2) begin cmd_valid = 1'b1; cmd_op = 2'd2; half_div = 8'(div + 3); end
      if (inject && k == 3) cmd_valid = 1'b0;
    end
    chk(k == want, "R2 access duration", k, want);
    chk(got_n == en, "R3 R5 R6 R7 bit count", got_n, en);
    chk(got_bits == eb, "R3 R5 R6 R7 bit stream", got_bits, eb);
    chk(sess_n == es, "R8 chip-select sessions", sess_n, es);
    exp_rd = (op == 0) ? pat : last_rd;
    chk(rdata == exp_rd, "R4 read word", rdata, exp_rd);
    last_rd = exp_rd;
    chk(timeout_err == ((op >= 2) && !rdy), "R9 timeout flag", timeout_err, (op >= 2) && !rdy);
    half_div = 8'(div);
    repeat (4) @(negedge clk);
    chk(done_cnt == 1 && !done, "R10 single done pulse", done_cnt, 1);
    chk(!busy && !ee_cs && !ee_sk && !ee_di, "R1 R11 idle after access",
        {busy, ee_cs, ee_sk, ee_di}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
    half_div = '0; ee_do = 1'b0; got_n = 0; sess_n = 0; rise_cnt = 0; done_cnt = 0;
    sk_prev = 1'b0; cs_prev = 1'b0; cur_pat = '0; ready_lvl = 1'b1; last_rd = '0;
    got_bits = '0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timeout_err && !ee_cs && !ee_sk && !ee_di && rdata == 16'h0,
        "R1 reset state", {busy, done, timeout_err, ee_cs, ee_sk, ee_di, rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !ee_cs, "R1 idle after release", {busy, ee_cs}, 0);

    // directed corners
    run_op(0, 6'h3f, 16'h0, 0, 1'b1, 16'h8001, 1'b0);   // R3 R4 fastest step
    run_op(0, 6'h00, 16'h0, 5, 1'b1, 16'h5a3c, 1'b0);   // R2 long step
    run_op(1, 6'h15, 16'h0, 1, 1'b1, 16'h0, 1'b0);      // R5
    run_op(2, 6'h2a, 16'hc0de, 2, 1'b1, 16'h0, 1'b0);   // R6 R8
    run_op(3, 6'h11, 16'h0, 1, 1'b1, 16'h0, 1'b0);      // R7
    run_op(2, 6'h01, 16'hffff, 0, 1'b0, 16'h0, 1'b0);   // R9 timeout
    run_op(3, 6'h02, 16'h0, 1, 1'b0, 16'h0, 1'b0);      // R9 timeout on erase
    run_op(0, 6'h24, 16'h0, 2, 1'b1, 16'h1357, 1'b1);   // R11 request and divider change while busy

    // constrained random mix
    for (int i = 0; i < 14; i++) begin
      run_op(int'($urandom_range(0, 3)), 6'($urandom), 16'($urandom),
             int'($urandom_range(0, 3)), 1'b1, 16'($urandom), 1'b0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule